// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog Timer

This block is a watchdog built around a 32-bit down-counter that runs on its own core clock. Software programs it through a small register bank on a separate bus clock that uses an APB-style handshake with no wait states. In the default two-phase mode the first time the count runs out it raises an interrupt and restarts from the programmed value. If software leaves that interrupt pending until the count runs out again, the block raises a system reset request, but only when reset generation is enabled. A mode bit selects a single-phase variant, in which the first expiry requests reset directly.

Control bits cross into the core domain through two-flop synchronisers. Load writes and interrupt clears cross as toggle-handshake pulses. The live count comes back to the bus side as a snapshot. The core side republishes the snapshot only after the bus side has acknowledged the previous one, so the bus never samples a word while it is changing. A reset request lasts a fixed number of core cycles. After one has fired, the watchdog stays quiet until software disables it and enables it again.

Top module: `wdt_top`

## Requirements
- R1: While enabled, the counter falls by one on every core-clock cycle. Its value can be read at offset 0x04, lagging the live count by a few cycles.
- R2: In two-phase mode (control bit2 = 0), when the counter reaches zero with no interrupt pending, `irq_o` rises and the counter reloads the load value. One period therefore lasts load+1 core cycles.
- R3: In two-phase mode with reset enabled (control bit1 = 1), reaching zero again while `irq_o` is still high raises `sys_rst_o` exactly load+1 core cycles after `irq_o` rose.
- R4: With control bit1 = 0, `sys_rst_o` never rises. `irq_o` stays high, and the counter keeps reloading.
- R5: In single-phase mode (control bit2 = 1) with bit1 = 1, the first zero raises `sys_rst_o` and `irq_o` never rises.
- R6: Writing a value with bit0 = 1 to offset 0x0C drops `irq_o` and reloads the counter. A watchdog that is serviced this way before each second expiry never requests reset.
- R7: Writing offset 0x00 stores the new load value, which reads back from 0x00, and restarts the counter from it.
- R8: `sys_rst_o` stays high for exactly HOLD_CYC (16) core cycles. No further reset is requested until control bit0 has been cleared and set again.
- R9: While control bit0 (enable) is 0, the counter holds its value, `irq_o` is low and `sys_rst_o` cannot rise.
- R10: After reset, `irq_o` and `sys_rst_o` are low, and the load (0x00) and control (0x08) registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock for register access |
| brst_n | input | 1 | Asynchronous active-low reset, bus domain |
| psel | input | 1 | Register bank select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits [3:2] pick the register |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid during the access phase |
| cclk | input | 1 | Core counting clock |
| crst_n | input | 1 | Asynchronous active-low reset, core domain |
| irq_o | output | 1 | Timeout interrupt, core domain |
| sys_rst_o | output | 1 | System reset request, core domain |

## Verification
The bench measures the gap from the interrupt's rising edge to the reset's rising edge in core cycles. A design that reloaded with load instead of load+1 cycles per period, or that fired reset on the first expiry, shows up as a wrong gap. It services the interrupt several periods in a row, and it checks that masking reset leaves the interrupt high with no reset. A design that ignored the pending flag or the mask would then produce an unexpected reset. It also measures the reset pulse width and checks that no reset repeats until the block is re-enabled: a design with a level-style reset or an unlatched fired state would fail there. Finally, it checks that a disabled counter freezes and that a load write restarts the count, which catches a counter that keeps running or ignores the reload.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        SEL_LOAD  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    localparam int CTRL_W      = 3;
    localparam int BIT_ENABLE  = 0;
    localparam int BIT_RST_EN  = 1;
    localparam int BIT_SINGLE  = 2;
endpackage

// File: rtl/wdt_sync2.sv
module wdt_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q, sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/wdt_pulse_sync.sv
module wdt_pulse_sync (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic src_pulse,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic dst_pulse
);
    logic       tgl_d, tgl_q;
    logic [2:0] sh_d, sh_q;

    always_comb begin
        tgl_d = src_pulse ? ~tgl_q : tgl_q;
        sh_d  = {sh_q[1:0], tgl_q};
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) tgl_q <= 1'b0;
        else            tgl_q <= tgl_d;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) sh_q <= '0;
        else            sh_q <= sh_d;
    end

    assign dst_pulse = sh_q[2] ^ sh_q[1];

    // R6
    pulse_single_chk: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        dst_pulse |-> sh_q[1] == tgl_q || sh_q[0] == sh_q[1]);
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W    = 32,
    parameter int HOLD_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rst_en,
    input  logic             single,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_pulse,
    input  logic             clr_pulse,
    input  logic             snap_ack,
    output logic             irq,
    output logic             sys_rst,
    output logic [CNT_W-1:0] cnt_snap,
    output logic             snap_tgl
);
    localparam int HOLD_W = $clog2(HOLD_CYC + 1);
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  load;
        logic              irq;
        logic              fired;
        logic              rst;
        logic [HOLD_W-1:0] rst_cnt;
        logic [CNT_W-1:0]  snap;
        logic              stgl;
    } core_t;

    core_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        if (s_q.rst) begin
            if (s_q.rst_cnt == HOLD_LAST) s_d.rst = 1'b0;
            s_d.rst_cnt = s_q.rst_cnt + HOLD_W'(1);
        end

        if (!en) begin
            s_d.irq   = 1'b0;
            s_d.fired = 1'b0;
        end else if (!s_q.fired) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = s_q.load;
                if (!single && !s_q.irq) begin
                    s_d.irq = 1'b1;
                end else if (rst_en) begin
                    s_d.fired   = 1'b1;
                    s_d.rst     = 1'b1;
                    s_d.rst_cnt = '0;
                end
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end

        if (clr_pulse) begin
            s_d.irq = 1'b0;
            s_d.cnt = s_q.load;
        end
        if (load_pulse) begin
            s_d.load = load_val;
            s_d.cnt  = load_val;
        end

        if (snap_ack == s_q.stgl) begin
            s_d.snap = s_q.cnt;
            s_d.stgl = ~s_q.stgl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq      = s_q.irq;
    assign sys_rst  = s_q.rst;
    assign cnt_snap = s_q.snap;
    assign snap_tgl = s_q.stgl;

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !s_q.fired && s_q.cnt != '0 && !load_pulse && !clr_pulse)
        |=> s_q.cnt == $past(s_q.cnt) - CNT_W'(1));
    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load_pulse && !clr_pulse) |=> $stable(s_q.cnt) && !s_q.irq);
    // R4
    rst_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.rst) |-> $past(rst_en) && $past(en));
    // R3
    second_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(s_q.rst) && !$past(single)) |-> $past(s_q.irq));
    // R8
    rst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rst && s_q.rst_cnt != HOLD_LAST) |=> s_q.rst);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int HOLD_CYC = 16
) (
    input  logic              bclk,
    input  logic              brst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              cclk,
    input  logic              crst_n,
    output logic              irq_o,
    output logic              sys_rst_o
);
    typedef struct packed {
        logic [DATA_W-1:0] load;
        logic [CTRL_W-1:0] ctrl;
        logic [DATA_W-1:0] snap;
        logic              ack;
    } bus_t;

    bus_t              b_d, b_q;
    reg_sel_e          sel;
    logic              wr, ld_req, clr_req;
    logic              ld_pulse_c, clr_pulse_c, ack_c, tgl_b, tgl_c;
    logic [CTRL_W-1:0] ctrl_c;
    logic [DATA_W-1:0] snap_c;

    assign sel = reg_sel_e'(paddr[3:2]);
    assign wr  = psel && penable && pwrite && (paddr[1:0] == 2'b00);

    always_comb begin
        b_d     = b_q;
        ld_req  = 1'b0;
        clr_req = 1'b0;
        if (wr) begin
            case (sel)
                SEL_LOAD: begin
                    b_d.load = pwdata;
                    ld_req   = 1'b1;
                end
                SEL_CTRL:  b_d.ctrl = pwdata[CTRL_W-1:0];
                SEL_CLEAR: clr_req  = pwdata[0];
                default: ;
            endcase
        end
        if (tgl_b != b_q.ack) begin
            b_d.snap = snap_c;
            b_d.ack  = tgl_b;
        end
    end

    always_ff @(posedge bclk or negedge brst_n) begin
        if (!brst_n) b_q <= '0;
        else         b_q <= b_d;
    end

    always_comb begin
        prdata = '0;
        case (sel)
            SEL_LOAD:  prdata = b_q.load;
            SEL_COUNT: prdata = b_q.snap;
            SEL_CTRL:  prdata = DATA_W'(b_q.ctrl);
            default:   prdata = '0;
        endcase
    end

    wdt_sync2 #(.W(CTRL_W)) i_ctrl_sync (
        .clk(cclk), .rst_n(crst_n), .d(b_q.ctrl), .q(ctrl_c));
    wdt_sync2 #(.W(1)) i_ack_sync (
        .clk(cclk), .rst_n(crst_n), .d(b_q.ack), .q(ack_c));
    wdt_sync2 #(.W(1)) i_tgl_sync (
        .clk(bclk), .rst_n(brst_n), .d(tgl_c), .q(tgl_b));

    wdt_pulse_sync i_load_ps (
        .src_clk(bclk), .src_rst_n(brst_n), .src_pulse(ld_req),
        .dst_clk(cclk), .dst_rst_n(crst_n), .dst_pulse(ld_pulse_c));
    wdt_pulse_sync i_clr_ps (
        .src_clk(bclk), .src_rst_n(brst_n), .src_pulse(clr_req),
        .dst_clk(cclk), .dst_rst_n(crst_n), .dst_pulse(clr_pulse_c));

    wdt_core #(.CNT_W(DATA_W), .HOLD_CYC(HOLD_CYC)) i_core (
        .clk(cclk), .rst_n(crst_n),
        .en(ctrl_c[BIT_ENABLE]), .rst_en(ctrl_c[BIT_RST_EN]), .single(ctrl_c[BIT_SINGLE]),
        .load_val(b_q.load), .load_pulse(ld_pulse_c), .clr_pulse(clr_pulse_c),
        .snap_ack(ack_c), .irq(irq_o), .sys_rst(sys_rst_o),
        .cnt_snap(snap_c), .snap_tgl(tgl_c));
endmodule

// File: tb/test_wdt_top.sv
module test_wdt_top;
    localparam int CLK_PERIOD = 8;
    localparam int BUS_PERIOD = 12;
    localparam int HOLD       = 16;

    logic        bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [3:0]  paddr = 0;
    logic [31:0] pwdata = 0, prdata;
    logic        irq_o, sys_rst_o;

    int total = 0, bad = 0;
    bit done = 0;
    longint ccyc = 0, irq_rise_cyc = 0, rst_rise_cyc = 0;
    int irq_rises = 0, rst_rises = 0, rst_width = 0, cur_width = 0;
    logic irq_prev = 0, rst_prev = 0;

    always #(CLK_PERIOD/2) cclk = ~cclk;
    always #(BUS_PERIOD/2) bclk = ~bclk;

    wdt_top i_wdt_top (
        .bclk(bclk), .brst_n(brst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cclk(cclk), .crst_n(crst_n),
        .irq_o(irq_o), .sys_rst_o(sys_rst_o));

    always @(negedge cclk) begin
        ccyc++;
        if (irq_o && !irq_prev) begin irq_rises++; irq_rise_cyc = ccyc; end
        if (sys_rst_o && !rst_prev) begin rst_rises++; rst_rise_cyc = ccyc; cur_width = 0; end
        if (sys_rst_o) cur_width++;
        if (!sys_rst_o && rst_prev) rst_width = cur_width;
        irq_prev = irq_o;
        rst_prev = sys_rst_o;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_core(input int n);
        repeat (n) @(negedge cclk);
    endtask

    task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge bclk); psel = 1; pwrite = 1; paddr = a; pwdata = d;
        @(negedge bclk); penable = 1;
        @(negedge bclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge bclk); psel = 1; pwrite = 0; paddr = a;
        @(negedge bclk); penable = 1; #1 d = prdata;
        @(negedge bclk); psel = 0; penable = 0;
    endtask

    task automatic wait_count(ref int ctr, input int base, input int limit);
        for (int i = 0; i < limit && ctr == base; i++) @(negedge cclk);
    endtask

    task automatic quiesce();
        apb_write(4'h8, 0);
        wait_core(40);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(irq_o == 0, "R10 irq", irq_o, 0);
        check(sys_rst_o == 0, "R10 rst", sys_rst_o, 0);
        apb_read(4'h0, d); check(d == 0, "R10 load", d, 0);
        apb_read(4'h8, d); check(d == 0, "R10 ctrl", d, 0);
    endtask

    task automatic t_two_phase();
        int ib, rb;
        apb_write(4'h0, 20);
        ib = irq_rises; rb = rst_rises;
        apb_write(4'h8, 3);
        wait_count(irq_rises, ib, 500);
        check(irq_rises == ib + 1, "R2 irq rose", irq_rises, ib + 1);
        wait_count(rst_rises, rb, 500);
        check(rst_rises == rb + 1, "R3 reset rose", rst_rises, rb + 1);
        check(rst_rise_cyc - irq_rise_cyc == 21, "R3 gap", rst_rise_cyc - irq_rise_cyc, 21);
        wait_core(HOLD + 5);
        check(rst_width == HOLD, "R8 width", rst_width, HOLD);
        wait_core(150);
        check(rst_rises == rb + 1, "R8 no repeat", rst_rises, rb + 1);
        apb_write(4'h8, 0); wait_core(10);
        apb_write(4'h8, 3);
        wait_count(rst_rises, rb + 1, 500);
        check(rst_rises == rb + 2, "R8 rearm", rst_rises, rb + 2);
        quiesce();
    endtask

    task automatic t_clear();
        int rb;
        apb_write(4'h0, 30);
        rb = rst_rises;
        apb_write(4'h8, 3);
        for (int k = 0; k < 3; k++) begin
            int ib = irq_rises;
            wait_count(irq_rises, ib, 500);
            apb_write(4'hC, 1);
            wait_core(10);
            check(irq_o == 0, "R6 cleared", irq_o, 0);
        end
        check(rst_rises == rb, "R6 no reset", rst_rises, rb);
        quiesce();
    endtask

    task automatic t_masked();
        int ib, rb;
        apb_write(4'h0, 20);
        ib = irq_rises; rb = rst_rises;
        apb_write(4'h8, 1);
        wait_count(irq_rises, ib, 500);
        wait_core(100);
        check(rst_rises == rb, "R4 no reset", rst_rises, rb);
        check(irq_o == 1, "R4 irq held", irq_o, 1);
        quiesce();
    endtask

    task automatic t_single();
        int ib, rb;
        apb_write(4'h0, 20);
        ib = irq_rises; rb = rst_rises;
        apb_write(4'h8, 7);
        wait_count(rst_rises, rb, 500);
        check(rst_rises == rb + 1, "R5 reset", rst_rises, rb + 1);
        check(irq_rises == ib, "R5 no irq", irq_rises, ib);
        quiesce();
    endtask

    task automatic t_disabled();
        logic [31:0] a, b;
        apb_write(4'h0, 500);
        wait_core(20);
        apb_read(4'h4, a);
        wait_core(50);
        apb_read(4'h4, b);
        check(a == 500, "R9 held value", a, 500);
        check(b == a, "R9 frozen", b, a);
        check(irq_o == 0, "R9 irq low", irq_o, 0);
    endtask

    task automatic t_count();
        logic [31:0] c1, c2, l;
        apb_write(4'h0, 100000);
        apb_write(4'h8, 1);
        wait_core(40);
        apb_read(4'h4, c1);
        wait_core(200);
        apb_read(4'h4, c2);
        check(c1 < 100000, "R1 counting", c1, 100000);
        check(c1 - c2 >= 180 && c1 - c2 <= 240, "R1 rate", c1 - c2, 200);
        apb_write(4'h0, 5000);
        wait_core(20);
        apb_read(4'h4, c1);
        check(c1 <= 5000 && c1 >= 4960, "R7 reload", c1, 5000);
        apb_read(4'h0, l);
        check(l == 5000, "R7 load readback", l, 5000);
        quiesce();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(BUS_PERIOD * 3 + 1);
        brst_n = 1; crst_n = 1;
        wait_core(5);
        t_reset();
        t_disabled();
        t_two_phase();
        t_clear();
        t_masked();
        t_single();
        t_count();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule